// File: doc/BRIEF.md
# Timed Power Rail Sequencer

This block switches a set of power-rail enables on and off in a timed order. When the hardware enable input is held high while the block is idle, a fixed bias window runs first. After that, each rail is released when the count of base ticks reaches a per-rail start time. A rail's start time is its 3-bit slot code plus one, multiplied by a fixed number of base ticks. When the enable input drops, the rails that are on are released in the reverse of their start order. The spacing between releases mirrors the spacing between starts.

The block also does the following:
- It drives one output-discharge control per rail. These hold every rail output at discharge until the ON state is reached. In the ON state, each control follows its own configuration bit.
- It drives a power-good flag, which rises a fixed number of clocks after the last rail starts, together with a sticky interrupt.
- It drives a bus-ready flag. This flag is held low while input power is invalid and for a short blanking window of base ticks after power becomes valid.

An undervoltage condition drops every output at once, with no reverse sequence, and returns the sequencer to idle.

Top module: `rail_seq`

## Requirements
- R1: After reset, and whenever `uv_ok_i` is low, all rail enables are 0, `pg_o` and `pg_irq_o` are 0, every discharge control is 1 and `bus_rdy_o` is 0.
- R2: With `en_i` high in idle, the sequencer first counts BIAS_TICKS base ticks (clock edges with `tick_i`=1). It then counts ramp ticks from zero. Rail r (bits [r*SLOT_W +: SLOT_W] of `slot_cfg_i`) turns on at the edge of ramp tick (slot_r+1)*UNIT_TICKS, provided no other rail starts on that tick.
- R3: At most one rail turns on per base tick. When several rails are due together, the lowest rail index starts first and the others follow on later ticks.
- R4: After `en_i` falls, count base ticks from the fall. Let t_last be the ramp tick at which the last-started rail turned on, and t_r the ramp tick at which rail r turned on. Rail r turns off at tick UNIT_TICKS + (t_last − t_r), so rails go off one at a time in reverse start order.
- R5: If `en_i` falls during the bias window, the ramp or the power-good wait, no further rail starts. The rails already on are released under the R4 rule.
- R6: In the ON state, `dis_o` equals `dis_cfg_i`. In every other state, all discharge controls are 1.
- R7: `pg_o` rises exactly 17 clock cycles after the edge that turns the last rail on, and it is 1 only in the ON state.
- R8: `pg_irq_o` sets on the edge where `pg_o` rises. It clears on an edge with `pg_ack_i`=1 or `en_i`=0; if it sets and is acknowledged on the same edge, the set wins.
- R9: `bus_rdy_o` rises once BLANK_TICKS base ticks have been seen since `uv_ok_i` last became high.
- R10: An edge with `uv_ok_i` low turns all rails off at once, with no reverse schedule. Once power returns, a new sequence starts if `en_i` is high.
- R11: Raising `en_i` while rails are still being released does not restart any rail. A new sequence begins only after every rail is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Hardware enable level |
| uv_ok_i | input | 1 | Input supply above undervoltage threshold |
| tick_i | input | 1 | Base tick strobe, one clock wide |
| slot_cfg_i | input | NUM_RAILS*SLOT_W | Per-rail start slot codes |
| dis_cfg_i | input | NUM_RAILS | Per-rail discharge setting in ON state |
| pg_ack_i | input | 1 | Interrupt acknowledge (status read) strobe |
| rail_en_o | output | NUM_RAILS | Rail enables |
| dis_o | output | NUM_RAILS | Output-discharge controls |
| pg_o | output | 1 | Power-good status |
| pg_irq_o | output | 1 | Power-good interrupt |
| bus_rdy_o | output | 1 | Serial bus may acknowledge |

## Verification
The bench targets three corner cases:
- Several rails share a slot code. A design that releases them together would raise two enables on one edge. A design that breaks ties the wrong way would start a higher-index rail first.
- The enable drops in the middle of the ramp, or rises again while rails are draining. A faulty design would keep starting rails, or turn rails back on before the drain finishes.
- The mirrored shutdown timing and the 17-cycle power-good delay. Either is off by one if a counter is cleared or compared one edge late.

Undervoltage drops are mixed into random runs with random tick spacing. These runs check that nothing is released one rail at a time and that the bus blanking restarts after each drop.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_BIAS,
    PH_RAMP,
    PH_SETTLE,
    PH_ON,
    PH_DRAIN
  } phase_e;

  // Counter width covering bias, ramp stamps and mirrored drain times.
  function automatic int cnt_bits(int nslots, int unit, int bias, int nr);
    int mx;
    mx = (nslots + 1) * unit + nr + 2;
    if (bias + 1 > mx) mx = bias + 1;
    return $clog2(mx + 1);
  endfunction

endpackage

// File: rtl/rseq_ctrl.sv
module rseq_ctrl
  import rseq_pkg::*;
#(
  parameter int NR      = 6,
  parameter int PG_CLKS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          uv_ok,
  input  logic          en,
  input  logic          ack,
  input  logic          bias_done,
  input  logic          all_on,
  input  logic          none_on,
  input  logic [NR-1:0] dis_cfg,
  output phase_e        phase,
  output logic          clr,
  output logic          load_top,
  output logic          pg,
  output logic          irq,
  output logic [NR-1:0] dis
);

  localparam int PW = $clog2(PG_CLKS + 1);

  phase_e        state_q, state_d;
  logic [PW-1:0] pgc_q, pgc_d;
  logic          irq_q, irq_d;
  logic          enter_on;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_IDLE:   if (en) state_d = PH_BIAS;
      PH_BIAS:   if (!en) state_d = PH_DRAIN;
                 else if (bias_done) state_d = PH_RAMP;
      PH_RAMP:   if (!en) state_d = PH_DRAIN;
                 else if (all_on) state_d = PH_SETTLE;
      PH_SETTLE: if (!en) state_d = PH_DRAIN;
                 else if (pgc_q == PW'(PG_CLKS - 1)) state_d = PH_ON;
      PH_ON:     if (!en) state_d = PH_DRAIN;
      PH_DRAIN:  if (none_on) state_d = PH_IDLE;
      default:   state_d = PH_IDLE;
    endcase

    pgc_d    = (state_q == PH_SETTLE) ? pgc_q + PW'(1) : '0;
    enter_on = (state_q == PH_SETTLE) && (state_d == PH_ON);

    if (enter_on)         irq_d = 1'b1;
    else if (ack || !en)  irq_d = 1'b0;
    else                  irq_d = irq_q;

    clr      = (state_d != state_q);
    load_top = (state_d == PH_DRAIN) && (state_q != PH_DRAIN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      pgc_q   <= '0;
      irq_q   <= 1'b0;
    end else if (!uv_ok) begin
      state_q <= PH_IDLE;
      pgc_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pgc_q   <= pgc_d;
      irq_q   <= irq_d;
    end
  end

  assign phase = state_q;
  assign pg    = (state_q == PH_ON);
  assign irq   = irq_q;
  assign dis   = pg ? dis_cfg : '1;

endmodule

// File: rtl/rseq_sched.sv
module rseq_sched
  import rseq_pkg::*;
#(
  parameter int NR   = 6,
  parameter int SW   = 3,
  parameter int UNIT = 128,
  parameter int BIAS = 64,
  parameter int CW   = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uv_ok,
  input  logic             en,
  input  logic             tick,
  input  phase_e           phase,
  input  logic             clr,
  input  logic             load_top,
  input  logic [NR*SW-1:0] slot_cfg,
  output logic [NR-1:0]    rail,
  output logic             bias_done,
  output logic             all_on,
  output logic             none_on
);

  logic [CW-1:0] cnt_q, cnt_d, cnt_inc;
  logic [CW-1:0] top_q, top_d, top_max;
  logic [CW-1:0] stamp_q [NR];
  logic [CW-1:0] stamp_d [NR];
  logic [CW-1:0] start_at [NR];
  logic [CW:0]   off_sum [NR];
  logic [CW:0]   off_lim;
  logic [NR-1:0] rail_q, rail_d, due_on, due_off;
  logic          counting;

  assign cnt_inc  = cnt_q + CW'(1);
  assign off_lim  = {1'b0, top_q} + (CW+1)'(UNIT);
  assign counting = tick && (phase == PH_BIAS || phase == PH_RAMP || phase == PH_DRAIN);

  // Per-rail start time, due flags for start and mirrored release.
  for (genvar r = 0; r < NR; r++) begin : g_rail
    assign start_at[r] = (CW'(slot_cfg[r*SW +: SW]) + CW'(1)) * CW'(UNIT);
    assign due_on[r]   = !rail_q[r] && (start_at[r] <= cnt_inc);
    assign off_sum[r]  = {1'b0, stamp_q[r]} + {1'b0, cnt_inc};
    assign due_off[r]  = rail_q[r] && (off_sum[r] >= off_lim);
  end

  always_comb begin
    top_max = '0;
    for (int r = 0; r < NR; r++) begin
      if (rail_q[r] && (stamp_q[r] > top_max)) top_max = stamp_q[r];
    end
  end

  always_comb begin
    logic found;
    found   = 1'b0;
    rail_d  = rail_q;
    stamp_d = stamp_q;
    if (phase == PH_RAMP && en && tick) begin
      for (int r = 0; r < NR; r++) begin
        if (!found && due_on[r]) begin
          found      = 1'b1;
          rail_d[r]  = 1'b1;
          stamp_d[r] = cnt_inc;
        end
      end
    end
    if (phase == PH_DRAIN && tick) rail_d = rail_q & ~due_off;

    if (clr)           cnt_d = '0;
    else if (counting) cnt_d = cnt_inc;
    else               cnt_d = cnt_q;

    top_d = load_top ? top_max : top_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      top_q  <= '0;
      rail_q <= '0;
      for (int r = 0; r < NR; r++) stamp_q[r] <= '0;
    end else if (!uv_ok) begin
      cnt_q  <= '0;
      top_q  <= '0;
      rail_q <= '0;
      for (int r = 0; r < NR; r++) stamp_q[r] <= '0;
    end else begin
      cnt_q  <= cnt_d;
      top_q  <= top_d;
      rail_q <= rail_d;
      for (int r = 0; r < NR; r++) stamp_q[r] <= stamp_d[r];
    end
  end

  assign rail      = rail_q;
  assign bias_done = tick && (cnt_q == CW'(BIAS - 1));
  assign all_on    = &rail_q;
  assign none_on   = ~|rail_q;

endmodule

// File: rtl/rseq_blank.sv
module rseq_blank #(
  parameter int BLANK = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_ok,
  input  logic tick,
  output logic rdy
);

  localparam int BW = $clog2(BLANK + 1);

  logic [BW-1:0] cnt_q, cnt_d;
  logic          at_end;

  assign at_end = (cnt_q == BW'(BLANK));

  always_comb begin
    cnt_d = cnt_q;
    if (tick && !at_end) cnt_d = cnt_q + BW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!uv_ok) cnt_q <= '0;
    else             cnt_q <= cnt_d;
  end

  assign rdy = at_end;

endmodule

// File: rtl/rail_seq.sv
module rail_seq
  import rseq_pkg::*;
#(
  parameter int NUM_RAILS   = 6,
  parameter int SLOT_W      = 3,
  parameter int UNIT_TICKS  = 128,
  parameter int BIAS_TICKS  = 64,
  parameter int BLANK_TICKS = 50,
  parameter int PG_CLKS     = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en_i,
  input  logic                        uv_ok_i,
  input  logic                        tick_i,
  input  logic [NUM_RAILS*SLOT_W-1:0] slot_cfg_i,
  input  logic [NUM_RAILS-1:0]        dis_cfg_i,
  input  logic                        pg_ack_i,
  output logic [NUM_RAILS-1:0]        rail_en_o,
  output logic [NUM_RAILS-1:0]        dis_o,
  output logic                        pg_o,
  output logic                        pg_irq_o,
  output logic                        bus_rdy_o
);

  localparam int NUM_SLOTS = 1 << SLOT_W;
  localparam int CW        = cnt_bits(NUM_SLOTS, UNIT_TICKS, BIAS_TICKS, NUM_RAILS);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  phase_e     phase;
  logic       clr, load_top, bias_done, all_on, none_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rseq_ctrl #(
    .NR      (NUM_RAILS),
    .PG_CLKS (PG_CLKS)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .uv_ok     (uv_ok_i),
    .en        (en_i),
    .ack       (pg_ack_i),
    .bias_done (bias_done),
    .all_on    (all_on),
    .none_on   (none_on),
    .dis_cfg   (dis_cfg_i),
    .phase     (phase),
    .clr       (clr),
    .load_top  (load_top),
    .pg        (pg_o),
    .irq       (pg_irq_o),
    .dis       (dis_o)
  );

  rseq_sched #(
    .NR   (NUM_RAILS),
    .SW   (SLOT_W),
    .UNIT (UNIT_TICKS),
    .BIAS (BIAS_TICKS),
    .CW   (CW)
  ) u_sched (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .uv_ok     (uv_ok_i),
    .en        (en_i),
    .tick      (tick_i),
    .phase     (phase),
    .clr       (clr),
    .load_top  (load_top),
    .slot_cfg  (slot_cfg_i),
    .rail      (rail_en_o),
    .bias_done (bias_done),
    .all_on    (all_on),
    .none_on   (none_on)
  );

  rseq_blank #(
    .BLANK (BLANK_TICKS)
  ) u_blank (
    .clk   (clk),
    .rst_n (rst_int_n),
    .uv_ok (uv_ok_i),
    .tick  (tick_i),
    .rdy   (bus_rdy_o)
  );

endmodule

// File: rtl/rail_seq_chk.sv
module rail_seq_chk #(
  parameter int NR = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_i,
  input logic          uv_ok_i,
  input logic          pg_o,
  input logic          pg_irq_o,
  input logic          bus_rdy_o,
  input logic [NR-1:0] rail_en_o,
  input logic [NR-1:0] dis_o
);

  a_r3_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rail_en_o & ~$past(rail_en_o)) <= 1);

  a_r2_start_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    ((rail_en_o & ~$past(rail_en_o)) != '0) |-> ($past(en_i) && $past(uv_ok_i)));

  a_r6_discharge_off_state: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_o |-> (dis_o == '1));

  a_r7_pg_all_rails: assert property (@(posedge clk) disable iff (!rst_n)
    pg_o |-> (rail_en_o == '1));

  a_r8_irq_with_pg: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_irq_o) |-> pg_o);

  a_r10_uv_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    !uv_ok_i |=> (rail_en_o == '0 && !pg_o));

  a_r9_bus_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    !uv_ok_i |=> !bus_rdy_o);

endmodule

bind rail_seq rail_seq_chk #(.NR(NUM_RAILS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_i      (en_i),
  .uv_ok_i   (uv_ok_i),
  .pg_o      (pg_o),
  .pg_irq_o  (pg_irq_o),
  .bus_rdy_o (bus_rdy_o),
  .rail_en_o (rail_en_o),
  .dis_o     (dis_o)
);

// File: tb/rail_seq_bench.sv
`timescale 1ns/1ps
module rail_seq_bench;

  localparam int NR    = 6;
  localparam int SW    = 3;
  localparam int UNIT  = 4;
  localparam int BIAS  = 3;
  localparam int BLANK = 5;
  localparam int PGC   = 16;
  localparam logic [NR*SW-1:0] DEF_SLOTS = {3'd6, 3'd5, 3'd4, 3'd3, 3'd1, 3'd0};

  logic clk = 1'b0;
  logic rst_n, en, uv, tk, ack;
  logic [NR*SW-1:0] slot_cfg;
  logic [NR-1:0]    dis_cfg;
  logic [NR-1:0]    rail_en_o, dis_o;
  logic             pg_o, pg_irq_o, bus_rdy_o;

  always #2.5 clk = ~clk;

  rail_seq #(
    .NUM_RAILS   (NR),
    .SLOT_W      (SW),
    .UNIT_TICKS  (UNIT),
    .BIAS_TICKS  (BIAS),
    .BLANK_TICKS (BLANK),
    .PG_CLKS     (PGC)
  ) u_rail_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en),
    .uv_ok_i    (uv),
    .tick_i     (tk),
    .slot_cfg_i (slot_cfg),
    .dis_cfg_i  (dis_cfg),
    .pg_ack_i   (ack),
    .rail_en_o  (rail_en_o),
    .dis_o      (dis_o),
    .pg_o       (pg_o),
    .pg_irq_o   (pg_irq_o),
    .bus_rdy_o  (bus_rdy_o)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int tmode = 0;
  bit rack  = 0;
  string rtag = "R2";

  // Reference model state: 0 idle,1 bias,2 ramp,3 settle,4 on,5 drain
  int          mph, mcnt, mpgc, mtop, mbl;
  logic [NR-1:0] mon;
  logic        mirq;
  int          mst [NR];
  logic [NR-1:0] p_rails;
  logic        p_pg;
  int          lat;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int slot_of(int r);
    return int'(slot_cfg[r*SW +: SW]);
  endfunction

  task automatic enter_drain();
    int tmax;
    tmax = 0;
    for (int r = 0; r < NR; r++) if (mon[r] && mst[r] > tmax) tmax = mst[r];
    mtop = tmax;
    mph  = 5;
    mcnt = 0;
  endtask

  task automatic m_step();
    int c;
    bit go_on;
    if (!uv) begin
      mph = 0; mon = '0; mcnt = 0; mpgc = 0; mirq = 1'b0; mbl = 0; mtop = 0;
      return;
    end
    if (tk && mbl < BLANK) mbl++;
    go_on = 0;
    case (mph)
      0: if (en) begin mph = 1; mcnt = 0; end
      1: if (!en) enter_drain();
         else if (tk) begin
           if (mcnt == BIAS - 1) begin mph = 2; mcnt = 0; end
           else mcnt++;
         end
      2: if (!en) enter_drain();
         else if (mon == '1) begin mph = 3; mpgc = 0; mcnt = 0; end
         else if (tk) begin
           c = mcnt + 1;
           for (int r = 0; r < NR; r++) begin
             if (!mon[r] && (slot_of(r) + 1) * UNIT <= c) begin
               mon[r] = 1'b1; mst[r] = c; break;
             end
           end
           mcnt = c;
         end
      3: if (!en) enter_drain();
         else if (mpgc == PGC - 1) begin mph = 4; go_on = 1; end
         else mpgc++;
      4: if (!en) enter_drain();
      default: if (mon == '0) begin mph = 0; mcnt = 0; end
         else if (tk) begin
           c = mcnt + 1;
           for (int r = 0; r < NR; r++)
             if (mon[r] && mst[r] + c >= UNIT + mtop) mon[r] = 1'b0;
           mcnt = c;
         end
    endcase
    if (go_on) mirq = 1'b1;
    else if (ack || !en) mirq = 1'b0;
  endtask

  task automatic compare();
    logic [NR-1:0] rises, falls;
    rises = rail_en_o & ~p_rails;
    falls = p_rails & ~rail_en_o;
    if (!uv) chk(rail_en_o == '0 && !pg_o, "R10", "uv off", rail_en_o, 0);
    if (rises != '0) chk($countones(rises) == 1, "R3", "starts per edge", rises, 0);
    if (falls != '0 && uv) chk($countones(falls) == 1, "R4", "releases per edge", falls, 0);
    chk(rail_en_o == mon, rtag, "rail enables", rail_en_o, mon);
    chk(dis_o == ((mph == 4) ? dis_cfg : '1), "R6", "discharge", dis_o, (mph == 4) ? dis_cfg : '1);
    chk(pg_o == (mph == 4), "R7", "power good", pg_o, mph == 4);
    chk(pg_irq_o == mirq, "R8", "interrupt", pg_irq_o, mirq);
    chk(bus_rdy_o == (mbl == BLANK), "R9", "bus ready", bus_rdy_o, mbl == BLANK);
    if (rail_en_o == '1 && p_rails != '1) lat = 0;
    else if (lat < 100000) lat++;
    if (pg_o && !p_pg) chk(lat == 17, "R7", "pg latency", lat, 17);
    p_rails = rail_en_o;
    p_pg    = pg_o;
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    m_step();
    compare();
    ack = rack ? ($urandom % 16 == 0) : 1'b0;
    tk  = (tmode == 0) ? 1'b1 : ($urandom % 3 == 0);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic drain_out();
    en = 1'b0;
    for (int i = 0; i < 800; i++) begin
      cyc();
      if (mph == 0 && mon == '0) break;
    end
    run(3);
  endtask

  initial begin
    logic [NR-1:0] r0;
    void'($urandom(32'd4242));
    rst_n = 1'b0; en = 1'b0; uv = 1'b0; tk = 1'b1; ack = 1'b0;
    slot_cfg = DEF_SLOTS; dis_cfg = 6'b010110;
    mph = 0; mon = '0; mcnt = 0; mpgc = 0; mirq = 1'b0; mbl = 0; mtop = 0;
    for (int r = 0; r < NR; r++) mst[r] = 0;
    p_rails = '0; p_pg = 1'b0; lat = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    run(4);
    // R1: idle state after reset
    chk(rail_en_o == '0 && !pg_o && !pg_irq_o && dis_o == '1 && !bus_rdy_o,
        "R1", "reset state", {rail_en_o, dis_o}, {6'h00, 6'h3f});

    uv = 1'b1;
    run(10);

    // R2/R4: default slot order, tick every clock, ack during ON
    rtag = "R2"; tmode = 0; en = 1'b1;
    run(80);
    ack = 1'b1; cyc();
    chk(!pg_irq_o, "R8", "ack clears irq", pg_irq_o, 0);
    run(5);
    rtag = "R4";
    drain_out();

    // R3: every rail on the same slot
    rtag = "R3"; slot_cfg = {NR{3'd2}}; en = 1'b1;
    run(60);
    drain_out();

    // R5: abort mid-ramp
    rtag = "R5"; slot_cfg = DEF_SLOTS; en = 1'b1;
    run(16);
    drain_out();
    chk(rail_en_o == '0, "R5", "abort leaves all off", rail_en_o, 0);

    // R10: undervoltage during ON, restart with enable still high
    rtag = "R10"; en = 1'b1;
    run(70);
    uv = 1'b0; run(3);
    uv = 1'b1; run(80);
    drain_out();

    // R11: enable rises while draining
    rtag = "R11"; en = 1'b1;
    run(70);
    en = 1'b0; run(6);
    r0 = rail_en_o; en = 1'b1;
    cyc(); cyc();
    chk((rail_en_o & ~r0) == '0, "R11", "no restart while draining", rail_en_o, r0);
    run(140);
    drain_out();

    // Random runs
    rtag = "R2";
    for (int it = 0; it < 30; it++) begin
      tmode = $urandom % 2;
      rack = 1'b1;
      slot_cfg = (NR*SW)'($urandom);
      dis_cfg  = NR'($urandom);
      en = 1'b1;
      run(20 + $urandom % 160);
      if ($urandom % 5 == 0) begin
        uv = 1'b0; run(2); uv = 1'b1; run(30);
      end
      drain_out();
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule